// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits behind the byte-load sequencer of a page-programmed nonvolatile store and watches every latched load (a 15-bit address with an 8-bit value). It picks out keyed command sequences from that stream. All of them start with the value AA at the first key address (5555 hex) followed by 55 at the second key address (2AAA hex). The sequences control three things: a software write guard, an identification read mode, and whether the page bytes that follow may be written. A load that is not consumed by a sequence is passed on as page data. If the guard blocks it, the load is turned into a dummy program cycle that stores nothing.

Once the guard is engaged, each program cycle has to be opened with the three-load write prefix. The guard closes again when the page sequencer reports that the cycle has ended. A six-load sequence releases the guard and another six-load sequence requests a full erase. Two three-load sequences enter and leave identification mode after a programmable settling delay. While the block is in identification mode, reads return fixed code bytes chosen by address bit 0.

Top module: `unlock_seq_decoder`

## Requirements
- R1: After reset, prot_on equals the PROT_RST parameter (default 0), wr_permit equals its inverse, and id_mode, dummy_cycle, data_we and erase_req are 0.
- R2: With the guard off, a load that is not a sequence step raises data_we for exactly the cycle after the strobe and leaves dummy_cycle at 0.
- R3: Loads AA@5555, 55@2AAA, A0@5555 produce no data_we. They set prot_on and open wr_permit, and later loads are passed as data until cycle_done.
- R4: With the guard on, a cycle_done pulse closes wr_permit and leaves prot_on at 1.
- R5: With the guard on and no prefix given, a data load gives no data_we and sets dummy_cycle, which holds until cycle_done.
- R6: Loads AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 clear prot_on, after which plain loads are written.
- R7: A load that fails the expected address or value aborts the matcher. It is handled as data, and the next load is compared against the first step again.
- R8: AA@5555, 55@2AAA, 90@5555 sets id_mode exactly PAUSE_CYC cycles after the final strobe, and not earlier.
- R9: AA@5555, 55@2AAA, F0@5555 clears id_mode exactly PAUSE_CYC cycles after the final strobe.
- R10: id_byte is 1F when id_mode=1 and rd_a0=0, DC when id_mode=1 and rd_a0=1, and 00 when id_mode=0.
- R11: The six-load sequence that ends in 10@5555 (instead of 20) raises erase_req for one cycle and leaves prot_on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | One-cycle strobe of a latched byte load |
| ld_addr | input | ADDR_W | Address of the load |
| ld_data | input | 8 | Value of the load |
| cycle_done | input | 1 | End of a program cycle, from the page sequencer |
| rd_a0 | input | 1 | Address bit 0 of the current read |
| wr_permit | output | 1 | Page loads are currently written |
| prot_on | output | 1 | Software write guard engaged |
| id_mode | output | 1 | Identification read mode active |
| dummy_cycle | output | 1 | Current program cycle is blocked and stores nothing |
| data_we | output | 1 | One-cycle write pulse for a passed page byte |
| erase_req | output | 1 | One-cycle full-erase request |
| id_byte | output | 8 | Identification code for the current read |

## Verification
The assertions check, on every cycle, that a write pulse only follows a cycle in which writes were permitted, and that the guard state changes only after a load strobe. They also check that engaging the guard always opens the write window, that cycle_done shuts that window while the guard stays on, and that an erase request lasts one cycle. The exact key values and addresses, the abort and restart behaviour of the matcher, the settling delay of identification mode and the read codes can only be shown by the bench's scenarios. For the abort case the bench sweeps every third-step value that is not a command.

// File: rtl/ucd_pkg.sv
package ucd_pkg;
   localparam logic [7:0] KEY_FIRST  = 8'hAA;
   localparam logic [7:0] KEY_SECOND = 8'h55;
   localparam logic [7:0] OP_WRITE   = 8'hA0;
   localparam logic [7:0] OP_EXTEND  = 8'h80;
   localparam logic [7:0] OP_ID_IN   = 8'h90;
   localparam logic [7:0] OP_ID_OUT  = 8'hF0;
   localparam logic [7:0] OP_RELEASE = 8'h20;
   localparam logic [7:0] OP_ERASE   = 8'h10;
   localparam logic [7:0] CODE_MAKER = 8'h1F;
   localparam logic [7:0] CODE_PART  = 8'hDC;

   typedef enum logic [2:0] {
      EV_NONE, EV_DATA, EV_UNLOCK, EV_RELEASE, EV_ERASE, EV_ID_IN, EV_ID_OUT
   } ucd_ev_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_K1, ST_K2, ST_X0, ST_X1, ST_X2
   } ucd_st_e;
endpackage

// File: rtl/ucd_match.sv
module ucd_match
   import ucd_pkg::*;
#(
   parameter int              ADDR_W = 15,
   parameter logic [ADDR_W-1:0] KEY_A = 'h5555,
   parameter logic [ADDR_W-1:0] KEY_B = 'h2AAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        data,
   input  logic              freeze,
   output ucd_ev_e           ev
);
   ucd_st_e st_q, st_d;
   logic    hit_a, hit_b;

   assign hit_a = (addr == KEY_A);
   assign hit_b = (addr == KEY_B);

   always_comb begin
      st_d = st_q;
      ev   = EV_NONE;
      if (stb) begin
         ev   = EV_DATA;
         st_d = ST_IDLE;
         if (!freeze) begin
            case (st_q)
               ST_IDLE: if (hit_a && data == KEY_FIRST)  begin ev = EV_NONE; st_d = ST_K1; end
               ST_K1:   if (hit_b && data == KEY_SECOND) begin ev = EV_NONE; st_d = ST_K2; end
               ST_K2: if (hit_a) begin
                  case (data)
                     OP_WRITE:  ev = EV_UNLOCK;
                     OP_EXTEND: begin ev = EV_NONE; st_d = ST_X0; end
                     OP_ID_IN:  ev = EV_ID_IN;
                     OP_ID_OUT: ev = EV_ID_OUT;
                     default:   ev = EV_DATA;
                  endcase
               end
               ST_X0:   if (hit_a && data == KEY_FIRST)  begin ev = EV_NONE; st_d = ST_X1; end
               ST_X1:   if (hit_b && data == KEY_SECOND) begin ev = EV_NONE; st_d = ST_X2; end
               ST_X2: if (hit_a) begin
                  if (data == OP_RELEASE)    ev = EV_RELEASE;
                  else if (data == OP_ERASE) ev = EV_ERASE;
               end
               default: st_d = ST_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/ucd_pause.sv
module ucd_pause #(
   parameter int PAUSE_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic target,
   output logic mode_q
);
   generate
      if (PAUSE_CYC == 0) begin : g_direct
         always_ff @(posedge clk) begin
            if (!rst_n)     mode_q <= 1'b0;
            else if (start) mode_q <= target;
         end
      end else begin : g_timed
         localparam int CNT_W = $clog2(PAUSE_CYC + 1);
         logic [CNT_W-1:0] cnt_q;
         logic             tgt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q  <= '0;
               tgt_q  <= 1'b0;
               mode_q <= 1'b0;
            end else if (start) begin
               cnt_q <= CNT_W'(PAUSE_CYC);
               tgt_q <= target;
            end else if (cnt_q != '0) begin
               cnt_q <= cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) mode_q <= tgt_q;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/ucd_guard.sv
module ucd_guard
   import ucd_pkg::*;
#(
   parameter bit PROT_RST = 1'b0
) (
   input  logic    clk,
   input  logic    rst_n,
   input  ucd_ev_e ev,
   input  logic    cycle_done,
   output logic    prot_q,
   output logic    unl_q,
   output logic    dummy_q,
   output logic    we_q,
   output logic    erase_q
);
   logic open_now;
   assign open_now = !prot_q || unl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prot_q  <= PROT_RST;
         unl_q   <= 1'b0;
         dummy_q <= 1'b0;
         we_q    <= 1'b0;
         erase_q <= 1'b0;
      end else begin
         we_q    <= (ev == EV_DATA) && open_now;
         erase_q <= (ev == EV_ERASE);
         if (ev == EV_UNLOCK)       prot_q <= 1'b1;
         else if (ev == EV_RELEASE) prot_q <= 1'b0;
         if (cycle_done)            unl_q <= 1'b0;
         else if (ev == EV_UNLOCK)  unl_q <= 1'b1;
         if (cycle_done)            dummy_q <= 1'b0;
         else if (ev == EV_DATA && !open_now) dummy_q <= 1'b1;
      end
   end
endmodule

// File: rtl/unlock_seq_decoder.sv
module unlock_seq_decoder
   import ucd_pkg::*;
#(
   parameter int                ADDR_W    = 15,
   parameter logic [ADDR_W-1:0] KEY_A     = 'h5555,
   parameter logic [ADDR_W-1:0] KEY_B     = 'h2AAA,
   parameter int                PAUSE_CYC = 500000,
   parameter bit                PROT_RST  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_stb,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [7:0]        ld_data,
   input  logic              cycle_done,
   input  logic              rd_a0,
   output logic              wr_permit,
   output logic              prot_on,
   output logic              id_mode,
   output logic              dummy_cycle,
   output logic              data_we,
   output logic              erase_req,
   output logic [7:0]        id_byte
);
   if (ADDR_W < 2)      begin : g_bad_width $error("ADDR_W must be at least 2"); end
   if (KEY_A == KEY_B)  begin : g_bad_keys  $error("key addresses must differ"); end
   if (PAUSE_CYC < 0)   begin : g_bad_pause $error("PAUSE_CYC must not be negative"); end

   ucd_ev_e ev;
   logic    unl;
   logic    id_start, id_target;

   ucd_match #(.ADDR_W(ADDR_W), .KEY_A(KEY_A), .KEY_B(KEY_B)) match_i (
      .clk(clk), .rst_n(rst_n), .stb(ld_stb), .addr(ld_addr), .data(ld_data),
      .freeze(unl), .ev(ev)
   );

   ucd_guard #(.PROT_RST(PROT_RST)) guard_i (
      .clk(clk), .rst_n(rst_n), .ev(ev), .cycle_done(cycle_done),
      .prot_q(prot_on), .unl_q(unl), .dummy_q(dummy_cycle),
      .we_q(data_we), .erase_q(erase_req)
   );

   assign id_start  = (ev == EV_ID_IN) || (ev == EV_ID_OUT);
   assign id_target = (ev == EV_ID_IN);

   ucd_pause #(.PAUSE_CYC(PAUSE_CYC)) pause_i (
      .clk(clk), .rst_n(rst_n), .start(id_start), .target(id_target),
      .mode_q(id_mode)
   );

   assign wr_permit = !prot_on || unl;
   assign id_byte   = !id_mode ? 8'h00 : (rd_a0 ? CODE_PART : CODE_MAKER);
endmodule

// File: rtl/ucd_checker.sv
module ucd_checker (
   input logic clk,
   input logic rst_n,
   input logic ld_stb,
   input logic cycle_done,
   input logic wr_permit,
   input logic prot_on,
   input logic data_we,
   input logic erase_req
);
   assert_we_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_we |-> $past(wr_permit));

   assert_guard_by_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_on) |-> $past(ld_stb));

   assert_enable_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prot_on) |-> wr_permit);

   assert_rearm_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_on && cycle_done && !ld_stb) |=> (prot_on && !wr_permit));

   assert_erase_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |=> !erase_req);
endmodule

bind unlock_seq_decoder ucd_checker chk_i (
   .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .cycle_done(cycle_done),
   .wr_permit(wr_permit), .prot_on(prot_on), .data_we(data_we),
   .erase_req(erase_req)
);

// File: tb/unlock_seq_decoder_tb_top.sv
`timescale 1ns/1ps
module unlock_seq_decoder_tb_top;
   localparam int P = 6;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, ld_stb = 1'b0, cycle_done = 1'b0, rd_a0 = 1'b0;
   logic [14:0] ld_addr = '0;
   logic [7:0]  ld_data = '0;
   logic wr_permit, prot_on, id_mode, dummy_cycle, data_we, erase_req;
   logic [7:0] id_byte;
   logic wp2, pr2, im2, dc2, we2, er2;
   logic [7:0] ib2;
   int n_run = 0, n_fail = 0;

   unlock_seq_decoder #(.PAUSE_CYC(P)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
      .cycle_done(cycle_done), .rd_a0(rd_a0), .wr_permit(wr_permit), .prot_on(prot_on),
      .id_mode(id_mode), .dummy_cycle(dummy_cycle), .data_we(data_we),
      .erase_req(erase_req), .id_byte(id_byte));

   unlock_seq_decoder #(.PAUSE_CYC(P), .PROT_RST(1'b1)) dut2_i (
      .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
      .cycle_done(cycle_done), .rd_a0(rd_a0), .wr_permit(wp2), .prot_on(pr2),
      .id_mode(im2), .dummy_cycle(dc2), .data_we(we2), .erase_req(er2), .id_byte(ib2));

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic ld(logic [14:0] a, logic [7:0] d);
      @(negedge clk); ld_stb = 1'b1; ld_addr = a; ld_data = d;
      @(negedge clk); ld_stb = 1'b0;
   endtask

   task automatic done_pulse();
      @(negedge clk); cycle_done = 1'b1;
      @(negedge clk); cycle_done = 1'b0;
   endtask

   task automatic prefix(logic [7:0] op);
      ld(15'h5555, 8'hAA); chk("R3 key1 no write", data_we, 0);
      ld(15'h2AAA, 8'h55); chk("R3 key2 no write", data_we, 0);
      ld(15'h5555, op);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 prot reset", prot_on, 0);
      chk("R1 permit reset", wr_permit, 1);
      chk("R1 id reset", id_mode, 0);
      chk("R1 dummy reset", dummy_cycle, 0);
      chk("R1 we reset", data_we, 0);
      chk("R1 prot reset param", pr2, 1);
      chk("R1 permit reset param", wp2, 0);
      rst_n = 1'b1;

      ld(15'h0123, 8'h5A);
      chk("R2 plain write", data_we, 1);
      chk("R2 no dummy", dummy_cycle, 0);
      @(negedge clk);
      chk("R2 single pulse", data_we, 0);

      for (int v = 0; v < 256; v++) begin
         if (v == 8'hA0 || v == 8'h80 || v == 8'h90 || v == 8'hF0) continue;
         prefix(8'(v));
         chk("R7 bad op is data", data_we, 1);
         chk("R7 bad op keeps guard", prot_on, 0);
      end

      ld(15'h5555, 8'hAA);
      ld(15'h1234, 8'h55); chk("R7 bad addr is data", data_we, 1);
      ld(15'h5555, 8'hA0); chk("R7 restart from first step", data_we, 1);
      chk("R7 restart no guard", prot_on, 0);

      prefix(8'hA0);
      chk("R3 op no write", data_we, 0);
      chk("R3 guard on", prot_on, 1);
      chk("R3 permit open", wr_permit, 1);
      for (int i = 0; i < 4; i++) begin
         ld(15'h0040 + 15'(i), 8'(i)); chk("R3 page byte written", data_we, 1);
      end
      done_pulse();
      chk("R4 permit closed", wr_permit, 0);
      chk("R4 guard kept", prot_on, 1);

      ld(15'h0100, 8'h77);
      chk("R5 blocked no write", data_we, 0);
      chk("R5 dummy set", dummy_cycle, 1);
      @(negedge clk);
      chk("R5 dummy held", dummy_cycle, 1);
      done_pulse();
      chk("R5 dummy cleared", dummy_cycle, 0);

      prefix(8'hA0);
      ld(15'h0200, 8'h11); chk("R3 second cycle written", data_we, 1);
      done_pulse();
      chk("R4 rearm again", wr_permit, 0);

      prefix(8'h90);
      repeat (P - 1) @(negedge clk);
      chk("R8 id not early", id_mode, 0);
      @(negedge clk);
      chk("R8 id entered", id_mode, 1);
      for (int a = 0; a < 2; a++) begin
         rd_a0 = 1'(a); #1;
         chk("R10 id code", id_byte, a ? 8'hDC : 8'h1F);
      end
      prefix(8'hF0);
      repeat (P - 1) @(negedge clk);
      chk("R9 id held", id_mode, 1);
      @(negedge clk);
      chk("R9 id left", id_mode, 0);
      chk("R10 no code outside id", id_byte, 0);

      prefix(8'h80);
      ld(15'h5555, 8'hAA); ld(15'h2AAA, 8'h55); ld(15'h5555, 8'h10);
      chk("R11 erase pulse", erase_req, 1);
      chk("R11 guard unchanged", prot_on, 1);
      @(negedge clk);
      chk("R11 erase one cycle", erase_req, 0);

      prefix(8'h80);
      ld(15'h5555, 8'hAA); ld(15'h2AAA, 8'h55); ld(15'h5555, 8'h20);
      chk("R6 guard off", prot_on, 0);
      chk("R6 permit open", wr_permit, 1);
      ld(15'h0300, 8'h22); chk("R6 plain write after release", data_we, 1);

      prefix(8'h80);
      ld(15'h5555, 8'hAA); ld(15'h2AAA, 8'h55); ld(15'h5555, 8'h33);
      chk("R7 bad long op is data", data_we, 1);
      chk("R7 bad long op no erase", erase_req, 0);

      summary();
      $finish;
   end
endmodule